// File: doc/BRIEF.md
# Prefix-Length Signed Displacement Decoder

This block sits behind an instruction byte fetch path and turns a run of one, two or four bytes into one signed 32-bit displacement. The first byte it takes sets how long the field is. The leading one or two bits of that byte are a length tag, and the rest of the byte holds the highest value bits. Any further bytes follow from most significant to least significant. The block strips the tag, sign-extends what remains and hands the result downstream together with a length code. An operand can carry two displacements, so a second field may start in the cycle right after the first one ends.

Both data sides use valid/ready. A byte moves on a cycle where `in_valid` and `in_ready` are both high. A result moves on a cycle where `out_valid` and `out_ready` are both high. While a finished result is held and `out_ready` is low, the block drops `in_ready` and takes no further byte. The value and flags stay frozen until the result is taken. `flush` throws away a field that is only partly collected. During the flush cycle `flush` also holds `in_ready` low. A result that is already complete is not affected by `flush`.

Top module: `vdisp_decode`

## Requirements
- R1: If the first byte has bit 7 equal to 0, the field is one byte long. The value is bits 6..0, and `out_len` is 1.
- R2: If the first byte has bits 7..6 equal to 2'b10, the field is two bytes long. The value is 14 bits: bits 5..0 of the first byte followed by all of the second byte. `out_len` is 2.
- R3: If the first byte has bits 7..6 equal to 2'b11, the field is four bytes long. The value is 30 bits: bits 5..0 of the first byte followed by the next three bytes, most significant first. `out_len` is 3.
- R4: The top bit of the 7-, 14- or 30-bit value is copied into every higher bit of the 32-bit `out_value`.
- R5: While `out_ready` is high, `in_ready` stays high and each byte is taken in one cycle. Back-to-back fields therefore flow with no idle cycle. The result appears with `out_valid` in the cycle after its last byte is taken.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_value`, `out_len` and `out_err` hold steady.
- R7: The four-byte sequence E0 00 00 00 sets `out_err` to 1 on its result, with `out_len` 3 and `out_value` 0xE0000000. All four bytes are still consumed. `out_err` is 0 for every other field.
- R8: A cycle with `flush` high keeps `in_ready` low and drops any partly collected field. The next byte taken is decoded as a first byte.
- R9: Synchronous reset clears `out_valid`, sets `in_ready`, and drops any partly collected field.
- R10: Each field yields exactly one output handshake, and `out_len` is never 0 while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Drops a partly collected field |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_byte | input | 8 | Incoming field byte |
| out_valid | output | 1 | A decoded result is held |
| out_ready | input | 1 | Downstream takes the result |
| out_value | output | OUT_W | Sign-extended displacement |
| out_len | output | 2 | 1, 2 or 3 for a 1-, 2- or 4-byte field |
| out_err | output | 1 | Reserved four-byte encoding seen |

## Verification
The bench builds the block with the defaults: OUT_W of 32 and the reserved-pattern check turned on. These settings put the full 32-bit sign extension of all three forms within reach, including the most negative and the largest positive value of each form. They also cover the E0 00 00 00 flag and its one-bit neighbour that must not be flagged. With only the default width in play, a result wider than 32 bits is never exercised.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MAX_BYTES = 4;
  localparam int unsigned RAW_W     = BYTE_W * MAX_BYTES;

  typedef enum logic [1:0] {
    LC_NONE = 2'd0,
    LC_ONE  = 2'd1,
    LC_TWO  = 2'd2,
    LC_FOUR = 2'd3
  } lcode_t;
endpackage

// File: rtl/vdisp_prefix.sv
module vdisp_prefix
  import vdisp_pkg::*;
(
  input  logic [BYTE_W-1:0] lead,
  output lcode_t            code,
  output logic [1:0]        extra
);
  // The length tag sits in the top bits of the leading byte
  always_comb begin
    if (!lead[BYTE_W-1]) begin
      code  = LC_ONE;
      extra = 2'd0;
    end else if (!lead[BYTE_W-2]) begin
      code  = LC_TWO;
      extra = 2'd1;
    end else begin
      code  = LC_FOUR;
      extra = 2'd3;
    end
  end
endmodule

// File: rtl/vdisp_collect.sv
module vdisp_collect
  import vdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              done,
  output logic [RAW_W-1:0]  raw,
  output lcode_t            code
);
  localparam int unsigned ACC_W = RAW_W - BYTE_W;

  logic             busy;
  logic [1:0]       left;
  logic [ACC_W-1:0] acc;
  lcode_t           code_q;
  lcode_t           pre_code;
  logic [1:0]       pre_extra;

  vdisp_prefix u_prefix (
    .lead  (byte_in),
    .code  (pre_code),
    .extra (pre_extra)
  );

  always_comb begin
    done = take && (busy ? (left == 2'd1) : (pre_extra == 2'd0));
    raw  = busy ? {acc, byte_in} : {{ACC_W{1'b0}}, byte_in};
    code = busy ? code_q : pre_code;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      busy   <= 1'b0;
      left   <= 2'd0;
      acc    <= '0;
      code_q <= LC_NONE;
    end else if (take) begin
      if (!busy) begin
        acc    <= {{(ACC_W-BYTE_W){1'b0}}, byte_in};
        code_q <= pre_code;
        left   <= pre_extra;
        busy   <= (pre_extra != 2'd0);
      end else begin
        acc  <= {acc[ACC_W-BYTE_W-1:0], byte_in};
        left <= left - 2'd1;
        if (left == 2'd1) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdisp_extend.sv
module vdisp_extend
  import vdisp_pkg::*;
#(
  parameter int unsigned OUT_W     = 32,
  parameter bit          RSV_CHECK = 1'b1
) (
  input  logic [RAW_W-1:0] raw,
  input  lcode_t           code,
  output logic [OUT_W-1:0] value,
  output logic             err
);
  localparam logic [RAW_W-1:0] RSV_PAT = {8'hE0, {(RAW_W-8){1'b0}}};

  logic [OUT_W-1:0] ext [3];

  // One sign-extended candidate per form: 7, 14 and 30 value bits
  for (genvar g = 0; g < 3; g++) begin : g_form
    localparam int unsigned VW = (g == 0) ? BYTE_W - 1 :
                                 (g == 1) ? 2*BYTE_W - 2 : RAW_W - 2;
    assign ext[g] = {{(OUT_W-VW){raw[VW-1]}}, raw[VW-1:0]};
  end

  always_comb begin
    case (code)
      LC_ONE:  value = ext[0];
      LC_TWO:  value = ext[1];
      LC_FOUR: value = ext[2];
      default: value = '0;
    endcase
  end

  if (RSV_CHECK) begin : g_rsv
    assign err = (code == LC_FOUR) && (raw == RSV_PAT);
  end else begin : g_norsv
    assign err = 1'b0;
  end
endmodule

// File: rtl/vdisp_decode.sv
module vdisp_decode
  import vdisp_pkg::*;
#(
  parameter int unsigned OUT_W     = 32,
  parameter bit          RSV_CHECK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_value,
  output logic [1:0]       out_len,
  output logic             out_err
);
  logic             take;
  logic             done;
  logic [RAW_W-1:0] raw;
  lcode_t           code;
  logic [OUT_W-1:0] value_c;
  logic             err_c;

  assign in_ready = !flush && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  vdisp_collect u_collect (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .take    (take),
    .byte_in (in_byte),
    .done    (done),
    .raw     (raw),
    .code    (code)
  );

  vdisp_extend #(
    .OUT_W     (OUT_W),
    .RSV_CHECK (RSV_CHECK)
  ) u_extend (
    .raw   (raw),
    .code  (code),
    .value (value_c),
    .err   (err_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_len   <= 2'd0;
      out_err   <= 1'b0;
    end else if (done) begin
      out_valid <= 1'b1;
      out_value <= value_c;
      out_len   <= code;
      out_err   <= err_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vdisp_decode_chk.sv
module vdisp_decode_chk #(
  parameter int unsigned OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_value,
  input logic [1:0]       out_len,
  input logic             out_err
);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_value)
                                && $stable(out_len) && $stable(out_err));

  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_flush_block_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  p_open_r5: assert property (@(posedge clk) disable iff (rst)
    !flush && out_ready |-> in_ready);

  p_len_legal_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_len != 2'd0);

  p_err_form_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_len == 2'd3
      && out_value == {{(OUT_W-30){1'b1}}, 30'h2000_0000});

  p_short_sign_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == 2'd1 |->
      ((&out_value[OUT_W-1:6]) || !(|out_value[OUT_W-1:6])));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind vdisp_decode vdisp_decode_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_value (out_value),
  .out_len   (out_len),
  .out_err   (out_err)
);

// File: tb/vdisp_decode_tb.sv
module vdisp_decode_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_value;
  logic [1:0]  out_len;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stalls = 0;

  logic [31:0] got_val [64];
  logic [1:0]  got_len [64];
  logic        got_err [64];
  int          n_got = 0;

  vdisp_decode u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_len(out_len), .out_err(out_err)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && n_got < 64) begin
      got_val[n_got] = out_value;
      got_len[n_got] = out_len;
      got_err[n_got] = out_err;
      n_got = n_got + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      stalls = stalls + 1;
    end
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #3;
  endtask

  task automatic expect_out(input int idx, input logic [31:0] v,
                            input logic [1:0] l, input bit e, input string tag);
    if (idx >= n_got) begin
      chk(1'b0, tag, "missing result", 32'(n_got), 32'(idx + 1));
    end else begin
      chk(got_val[idx] == v && got_len[idx] == l && got_err[idx] == e, tag,
          "value/len/err", {got_val[idx]}, v);
      chk(got_len[idx] == l, tag, "len", 32'(got_len[idx]), 32'(l));
      chk(got_err[idx] == e, tag, "err", 32'(got_err[idx]), 32'(e));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_one_byte();
    int b0 = n_got;
    @(posedge clk); #2;
    push(8'h05); push(8'h7F); push(8'h40); idle(); settle();
    expect_out(b0,     32'h0000_0005, 2'd1, 1'b0, "R1");
    expect_out(b0 + 1, 32'hFFFF_FFFF, 2'd1, 1'b0, "R4");
    expect_out(b0 + 2, 32'hFFFF_FFC0, 2'd1, 1'b0, "R1");
  endtask

  task automatic t_two_byte();
    int b0 = n_got;
    push(8'h81); push(8'h23);
    push(8'hBF); push(8'hFF);
    push(8'hA0); push(8'h00); idle(); settle();
    expect_out(b0,     32'h0000_0123, 2'd2, 1'b0, "R2");
    expect_out(b0 + 1, 32'hFFFF_FFFF, 2'd2, 1'b0, "R4");
    expect_out(b0 + 2, 32'hFFFF_E000, 2'd2, 1'b0, "R2");
  endtask

  task automatic t_four_byte();
    int b0 = n_got;
    push(8'hC1); push(8'h02); push(8'h03); push(8'h04);
    push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFE);
    push(8'hDF); push(8'hFF); push(8'hFF); push(8'hFF); idle(); settle();
    expect_out(b0,     32'h0102_0304, 2'd3, 1'b0, "R3");
    expect_out(b0 + 1, 32'hFFFF_FFFE, 2'd3, 1'b0, "R4");
    expect_out(b0 + 2, 32'h1FFF_FFFF, 2'd3, 1'b0, "R3");
  endtask

  task automatic t_reserved();
    int b0 = n_got;
    push(8'hE0); push(8'h00); push(8'h00); push(8'h00);
    push(8'hE0); push(8'h00); push(8'h00); push(8'h01); idle(); settle();
    expect_out(b0,     32'hE000_0000, 2'd3, 1'b1, "R7");
    expect_out(b0 + 1, 32'hE000_0001, 2'd3, 1'b0, "R7");
  endtask

  task automatic t_back_to_back();
    int b0 = n_got;
    stalls = 0;
    push(8'h01); push(8'h82); push(8'h00); push(8'h03); push(8'h7E);
    idle(); settle();
    chk(stalls == 0, "R5", "stall cycles", 32'(stalls), 32'd0);
    chk(n_got - b0 == 4, "R10", "result count", 32'(n_got - b0), 32'd4);
    expect_out(b0,     32'h0000_0001, 2'd1, 1'b0, "R5");
    expect_out(b0 + 1, 32'h0000_0200, 2'd2, 1'b0, "R5");
    expect_out(b0 + 2, 32'h0000_0003, 2'd1, 1'b0, "R5");
    expect_out(b0 + 3, 32'hFFFF_FFFE, 2'd1, 1'b0, "R5");
  endtask

  task automatic t_backpressure();
    int b0 = n_got;
    out_ready = 1'b0;
    push(8'h11);
    in_byte = 8'h22;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R6", "out_valid held", 32'(out_valid), 32'd1);
      chk(in_ready == 1'b0, "R6", "in_ready under stall", 32'(in_ready), 32'd0);
      chk(out_value == 32'h11, "R6", "value held", out_value, 32'h11);
    end
    @(posedge clk); #2;
    out_ready = 1'b1;
    push(8'h22); idle(); settle();
    chk(n_got - b0 == 2, "R10", "one handshake each", 32'(n_got - b0), 32'd2);
    expect_out(b0,     32'h0000_0011, 2'd1, 1'b0, "R6");
    expect_out(b0 + 1, 32'h0000_0022, 2'd1, 1'b0, "R6");
  endtask

  task automatic t_flush();
    int b0 = n_got;
    push(8'hC0); push(8'h12); idle();
    flush = 1'b1;
    in_valid = 1'b1;
    in_byte = 8'h55;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8", "in_ready during flush", 32'(in_ready), 32'd0);
    @(posedge clk); #2;
    flush = 1'b0;
    push(8'h05); idle(); settle();
    chk(n_got - b0 == 1, "R8", "results after flush", 32'(n_got - b0), 32'd1);
    expect_out(b0, 32'h0000_0005, 2'd1, 1'b0, "R8");
  endtask

  task automatic t_reset_mid();
    int b0;
    push(8'h80); idle();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after mid reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after mid reset", 32'(in_ready), 32'd1);
    b0 = n_got;
    @(posedge clk); #2;
    push(8'h07); idle(); settle();
    expect_out(b0, 32'h0000_0007, 2'd1, 1'b0, "R9");
  endtask

  initial begin
    t_reset();
    t_one_byte();
    t_two_byte();
    t_four_byte();
    t_reserved();
    t_back_to_back();
    t_backpressure();
    t_flush();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule